// File: doc/BRIEF.md
# Routable Multi-Channel Threshold Alert

This block watches measurement results from four channels and raises one shared, active-low alert line when a programmed threshold is crossed. It holds four independent limit slots. Each slot is told which channel to watch and which kind of fault to look for. The fault kinds are shunt word above the limit, shunt word below the limit, bus word above the limit and bus word below the limit. Slots are not tied to channels. Two or more slots may watch the same channel with different checks, and each of them is evaluated on its own.

Measurements arrive one at a time with a channel index and a valid strobe. A shunt word is two's complement, and its LSB stands for 2.5 uV. A limit of 28800 (0x7080) therefore trips on shunt voltages above 72 mV. A bus word is unsigned. A slot that finds its condition met sets a sticky flag. Reading the status word returns all flags and clears them. A plain register port with separate write and read strobes programs the slots. Driving the enable input low returns every register to its default value.

Top module: `alert_router`

## Requirements
- R1: After reset, every slot setting word reads 0, every limit reads 0x7FFF, the status word reads 0 and alert_n is high.
- R2: A write to address i (0..3) sets the setting word of slot i. Bits [4:3] select the channel (00 = channel 1, 01 = channel 2, 10 = channel 3, 11 = channel 4) and bits [2:0] select the check. Reading back returns those five bits, with all higher bits reading 0.
- R3: A write to address 4+i sets the 16-bit limit of slot i, and a read of that address returns it.
- R4: Check code 001 flags a slot when the signed shunt word is strictly greater than the signed limit.
- R5: Check code 010 flags a slot when the signed shunt word is strictly less than the signed limit.
- R6: Check code 011 flags a slot when the unsigned bus word is strictly greater than the limit. Check code 100 flags it when the unsigned bus word is strictly less than the limit.
- R7: Check codes 000, 101, 110 and 111 never flag a slot.
- R8: A slot is evaluated only in a cycle where meas_valid is high and meas_chan equals the slot's channel field.
- R9: Slots that watch the same channel are evaluated independently. Status bit i belongs to slot i.
- R10: Flags are sticky. A read of address 8 returns the flags in bits [3:0] and clears them at that clock edge. A fault detected in the same cycle as the read stays set.
- R11: alert_n is low exactly when at least one slot flag is set. It changes on the clock edge that updates the flags.
- R12: While enable is low, all setting words, limits and flags return to their defaults, and writes and measurements have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces defaults |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (reading the status word clears it) |
| addr | input | 4 | Register address: 0-3 settings, 4-7 limits, 8 status |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr, combinational |
| meas_valid | input | 1 | Measurement strobe |
| meas_chan | input | 2 | Channel of the measurement (00 = channel 1) |
| meas_shunt | input | 16 | Signed shunt word |
| meas_bus | input | 16 | Unsigned bus word |
| alert_n | output | 1 | Shared alert, low while any flag is set |

## Verification
The hardest case to reach from the ports is a status read that lands in the same cycle as a new fault. The flag must survive the clear in that case, and the bench drives a read together with a tripping measurement on purpose to get there. Threshold boundaries are also easy to miss with random data alone. Equal values, the signed/unsigned split at 0x8000 and slots that share one channel are therefore hit by directed steps. A long random run then mixes setting changes, measurements and status reads.

// File: rtl/alert_router.sv
module alert_router #(
  parameter int NSLOT = 4,
  parameter int NCH   = 4,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          meas_valid,
  input  logic [1:0]    meas_chan,
  input  logic [DW-1:0] meas_shunt,
  input  logic [DW-1:0] meas_bus,
  output logic          alert_n
);
  localparam int CHW  = $clog2(NCH);
  localparam int CFGW = CHW + 3;
  localparam logic [AW-1:0] STAT_ADDR = AW'(2 * NSLOT);
  localparam logic [DW-1:0] LIM_RST = {1'b0, {(DW-1){1'b1}}};

  logic [CFGW-1:0]  cfg [NSLOT];
  logic [DW-1:0]    lim [NSLOT];
  logic             flag_q [NSLOT];
  logic [NSLOT-1:0] flags;
  logic [NSLOT-1:0] hit;

  wire clr = rd_en && (addr == STAT_ADDR);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    wire [2:0]     mask = cfg[i][2:0];
    wire [CHW-1:0] chan = cfg[i][CFGW-1:3];
    wire sh_gt = $signed(meas_shunt) > $signed(lim[i]);
    wire sh_lt = $signed(meas_shunt) < $signed(lim[i]);
    wire bu_gt = meas_bus > lim[i];
    wire bu_lt = meas_bus < lim[i];
    logic cond;

    always_comb begin
      case (mask)
        3'b001:  cond = sh_gt;
        3'b010:  cond = sh_lt;
        3'b011:  cond = bu_gt;
        3'b100:  cond = bu_lt;
        default: cond = 1'b0;
      endcase
    end

    assign hit[i]   = meas_valid && (meas_chan == chan) && cond;
    assign flags[i] = flag_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[i]    <= '0;
        lim[i]    <= LIM_RST;
        flag_q[i] <= 1'b0;
      end else if (!enable) begin
        cfg[i]    <= '0;
        lim[i]    <= LIM_RST;
        flag_q[i] <= 1'b0;
      end else begin
        if (wr_en && addr == AW'(i))         cfg[i] <= wdata[CFGW-1:0];
        if (wr_en && addr == AW'(NSLOT + i)) lim[i] <= wdata;
        flag_q[i] <= hit[i] | (flag_q[i] & ~clr);
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (addr == AW'(i))         rdata[CFGW-1:0] = cfg[i];
      if (addr == AW'(NSLOT + i)) rdata = lim[i];
    end
    if (addr == STAT_ADDR) rdata[NSLOT-1:0] = flags;
  end

  assign alert_n = ~|flags;
endmodule

module alert_router_chk #(
  parameter int NSLOT = 4,
  parameter int DW    = 16,
  parameter int AW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic          meas_valid,
  input logic [DW-1:0] lim0,
  input logic          alert_n
);
  localparam logic [AW-1:0] STAT_ADDR = AW'(2 * NSLOT);

  p_disable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> alert_n);

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rd_en && addr == STAT_ADDR && !meas_valid) |=> alert_n);

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !alert_n && !(rd_en && addr == STAT_ADDR)) |=> !alert_n);

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !meas_valid && alert_n) |=> alert_n);

  p_limit_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_en && addr == AW'(NSLOT)) |=> lim0 == $past(wdata));
endmodule

bind alert_router alert_router_chk #(.NSLOT(NSLOT), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wdata(wdata), .meas_valid(meas_valid), .lim0(lim[0]),
  .alert_n(alert_n)
);

// File: tb/alert_router_tb.sv
`timescale 1ns/1ps
module alert_router_tb_top;
  logic        clk = 0, rst_n = 0, enable = 1;
  logic        wr_en = 0, rd_en = 0, meas_valid = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0, meas_shunt = 0, meas_bus = 0;
  logic [1:0]  meas_chan = 0;
  logic [15:0] rdata;
  logic        alert_n;

  int n_chk = 0, n_fail = 0;
  logic [4:0]  m_cfg [4];
  logic [15:0] m_lim [4];
  logic [3:0]  m_flag;

  always #4 clk = ~clk;

  alert_router dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .meas_valid(meas_valid),
    .meas_chan(meas_chan), .meas_shunt(meas_shunt), .meas_bus(meas_bus),
    .alert_n(alert_n)
  );

  function automatic logic exp_hit(logic [4:0] c, logic [15:0] l, logic [1:0] ch,
                                   logic [15:0] sh, logic [15:0] bu);
    if (c[4:3] != ch) return 1'b0;
    case (c[2:0])
      3'b001:  return $signed(sh) > $signed(l);
      3'b010:  return $signed(sh) < $signed(l);
      3'b011:  return bu > l;
      3'b100:  return bu < l;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m_cfg[i] = 0; m_lim[i] = 16'h7FFF; end
    m_flag = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0; meas_valid = 0;
  endtask

  task automatic chk_alert(string tag);
    check(tag, {15'd0, alert_n}, {15'd0, ~|m_flag});
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1;
    tick();
    if (enable) begin
      if (a < 4) m_cfg[a[1:0]] = d[4:0];
      else if (a < 8) m_lim[a[1:0]] = d;
    end
  endtask

  task automatic apply_meas(logic [1:0] ch, logic [15:0] sh, logic [15:0] bu);
    if (enable)
      for (int i = 0; i < 4; i++)
        if (exp_hit(m_cfg[i], m_lim[i], ch, sh, bu)) m_flag[i] = 1'b1;
  endtask

  task automatic meas(string tag, logic [1:0] ch, logic [15:0] sh, logic [15:0] bu);
    meas_valid = 1; meas_chan = ch; meas_shunt = sh; meas_bus = bu;
    tick();
    apply_meas(ch, sh, bu);
    chk_alert(tag);
  endtask

  task automatic rd(string tag, logic [3:0] a);
    logic [15:0] e;
    addr = a; rd_en = 1; #1;
    if (a < 4) e = {11'd0, m_cfg[a[1:0]]};
    else if (a < 8) e = m_lim[a[1:0]];
    else e = {12'd0, m_flag};
    check(tag, rdata, e);
    tick();
    if (a == 8 && enable) m_flag = 0;
  endtask

  task automatic rd_with_meas(string tag, logic [1:0] ch, logic [15:0] sh, logic [15:0] bu);
    addr = 8; rd_en = 1; meas_valid = 1; meas_chan = ch; meas_shunt = sh; meas_bus = bu; #1;
    check(tag, rdata, {12'd0, m_flag});
    tick();
    m_flag = 0;
    apply_meas(ch, sh, bu);
    chk_alert(tag);
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #8;
    chk_alert("R1 alert idle");
    rd("R1 cfg default", 0);
    rd("R1 limit default", 7);
    rd("R1 status default", 8);

    wr(1, 16'h0011); rd("R2 cfg readback", 1);
    wr(1, 16'hFFFF); rd("R2 upper bits zero", 1);
    wr(6, 16'h7080); rd("R3 limit readback", 6);
    wr(1, 0); wr(6, 16'h7FFF);

    wr(0, 16'h0001); wr(4, 16'h7080);
    meas("R4 equal no trip", 0, 16'h7080, 0);
    meas("R4 negative no trip", 0, 16'h8000, 0);
    meas("R4 one above trips", 0, 16'h7081, 0);
    rd("R4 status", 8);
    chk_alert("R11 released after read");
    wr(0, 0);

    wr(1, 16'h000A); wr(5, 16'hFF00);
    meas("R5 equal no trip", 1, 16'hFF00, 0);
    meas("R5 below trips", 1, 16'hFEFF, 0);
    rd("R5 status", 8);
    wr(1, 0);

    wr(2, 16'h0013); wr(6, 16'h8000);
    meas("R6 bus over trips unsigned", 2, 0, 16'h8001);
    rd("R6 over status", 8);
    wr(2, 16'h0014); wr(6, 16'h0010);
    meas("R6 bus under equal no trip", 2, 0, 16'h0010);
    meas("R6 bus under trips", 2, 0, 16'h000F);
    rd("R6 under status", 8);
    wr(2, 0);

    wr(3, 16'h0005); wr(7, 16'h0000);
    meas("R7 code 101 silent", 0, 16'h7FFF, 16'hFFFF);
    wr(3, 16'h0007);
    meas("R7 code 111 silent", 0, 16'h8000, 16'hFFFF);
    rd("R7 status", 8);
    wr(3, 0);

    wr(0, 16'h0009); wr(4, 16'h0000);
    meas("R8 other channel ignored", 0, 16'h7000, 0);
    meas_chan = 1; meas_shunt = 16'h7000; tick(); chk_alert("R8 no strobe ignored");
    meas("R8 matching channel trips", 1, 16'h7000, 0);
    rd("R8 status", 8);

    wr(0, 16'h001B); wr(4, 16'h0100);
    wr(1, 16'h001B); wr(5, 16'h0100);
    wr(1, 16'h001B - 16'h0008 + 16'h0008); wr(1, 16'h001B);
    wr(1, {11'd0, 2'b11, 3'b011}); wr(0, {11'd0, 2'b11, 3'b001});
    meas("R9 bus only", 3, 16'h0050, 16'h0200);
    rd("R9 per-slot status", 8);
    meas("R9 both trip", 3, 16'h0200, 16'h0200);
    rd("R9 both bits", 8);

    meas("R10 prime flag", 3, 16'h0200, 0);
    rd_with_meas("R10 hit during clear", 3, 16'h0200, 0);
    rd("R10 flag kept", 8);
    rd("R10 cleared", 8);

    meas("R12 prime", 3, 16'h0200, 0);
    enable = 0; tick(); model_reset();
    chk_alert("R12 alert released");
    wr(0, 16'h0019); wr(4, 16'h1234);
    meas("R12 meas ignored", 0, 16'h7FFF, 16'hFFFF);
    enable = 1; #1;
    rd("R12 cfg default", 0);
    rd("R12 limit default", 4);
    rd("R12 status default", 8);

    for (int k = 0; k < 4000; k++) begin
      int op;
      op = $urandom_range(0, 9);
      if (op < 2) wr(4'($urandom_range(0, 3)), 16'($urandom_range(0, 31)));
      else if (op < 4) wr(4'($urandom_range(4, 7)), 16'($urandom));
      else if (op < 8) meas("R11 random alert", 2'($urandom), 16'($urandom), 16'($urandom));
      else if (op < 9) rd("R10 random status", 8);
      else rd("R3 random readback", 4'($urandom_range(0, 7)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule